// File: doc/BRIEF.md
# Fused Output Channel Controller

This block drives two discrete output channels. For each channel it merges an enable bit, a force-on bit and two requests from other logic (a window-compare match and a pulse-width request) into one registered drive signal. It also watches a raw fault flag for each channel, which comes from an external short-circuit or open-wire sensor. A fault counts only after it has stayed present for a minimum number of clock ticks. The control word selects, per channel, a short or a long minimum.

Each channel has a fuse mode. With fuse mode on, a recognized fault turns the channel off and latches its fault-status bit. The latch holds after the raw fault has gone. It clears only when software writes fuse mode off with the enable bit on. With fuse mode off, the channel keeps obeying its commands, and the fault-status bit only mirrors the filtered fault.

Top module: `fused_out_ctl`

## Requirements
- R1: When a channel's enable bit is 0, its drive output is 0 one clock after the bit is sampled, whatever the other requests are.
- R2: When enable is 1, force-on is 1 and the channel is not latched off, the drive output is 1 one clock later.
- R3: When enable is 1 and force-on is 0 (not latched), the drive output one clock later equals the OR of the compare and PWM requests.
- R4: Control word layout for channel n (n = 0 or 1): bit 4n+3 selects the long filter, bit 4n+2 is fuse mode, bit 4n+1 is enable, bit 4n is force-on. Bit n of every per-channel port belongs to channel n.
- R5: With the long-filter bit at 0, fault status rises on the FAST_TICKS-th rising edge at which the raw fault is sampled high without a gap, and not before.
- R6: With the long-filter bit at 1, the same rule applies with SLOW_TICKS edges.
- R7: A single edge at which the raw fault is sampled low restarts the count from zero.
- R8: With fuse mode at 0, fault status drops on the first edge at which the raw fault is sampled low, and the drive output keeps following R1 to R3 while the fault is present.
- R9: With fuse mode at 1, a recognized fault forces the drive output to 0 within two edges. Fault status stays at 1 after the raw fault goes away.
- R10: A latched channel is released only on an edge where its fuse-mode bit is 0 and its enable bit is 1. Fuse mode 0 with enable 0 keeps it latched.
- R11: A fault, a latch or a recovery on one channel leaves the other channel's drive and status unchanged.
- R12: During reset, and right after it, both drive outputs and both status bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_i | input | 8 | Per-channel control nibbles (long filter, fuse mode, enable, force-on) |
| cmp_req_i | input | 2 | Compare-match on request per channel |
| pwm_req_i | input | 2 | PWM on request per channel |
| fault_raw_i | input | 2 | Unfiltered fault flag per channel |
| drive_o | output | 2 | Registered output drive per channel |
| fault_sts_o | output | 2 | Fault status per channel |

## Verification
A wrong filter count shows up directly as a fault-status edge on the wrong clock. The bench therefore counts edges from the first high sample of the raw fault and checks the status on the edge before the threshold and on the threshold edge itself. A latch that is stuck or released early can be seen within two edges: the drive output stays on during a fused fault, or the status drops after the raw fault clears or after a recovery write with enable 0. A swapped bit in the control decode or a channel mix-up shows up in the sweep of all 64 combinations of control nibble and requests, which checks both channels on the next edge.

// File: rtl/fused_out_pkg.sv
package fused_out_pkg;
  typedef struct packed {
    logic long_flt;
    logic fuse_en;
    logic enable;
    logic force_on;
  } ch_ctrl_t;

  localparam int unsigned CTRL_BITS_PER_CH = 4;

  function automatic ch_ctrl_t get_ctrl(input logic [CTRL_BITS_PER_CH-1:0] nib);
    ch_ctrl_t c;
    c.long_flt = nib[3];
    c.fuse_en  = nib[2];
    c.enable   = nib[1];
    c.force_on = nib[0];
    return c;
  endfunction
endpackage

// File: rtl/fo_rst_sync.sv
module fo_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/fo_fault_filter.sv
module fo_fault_filter #(
  parameter int unsigned FAST_TICKS = 1000000,
  parameter int unsigned SLOW_TICKS = 12500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic long_sel,
  input  logic raw,
  output logic flt
);
  localparam int unsigned MAX_TICKS = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
  localparam int unsigned CNT_W = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(FAST_TICKS - 1);
  localparam logic [CNT_W-1:0] SLOW_LIM = CNT_W'(SLOW_TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim;
  logic             flt_q, flt_d;
  logic             at_lim;

  always_comb begin
    lim    = long_sel ? SLOW_LIM : FAST_LIM;
    at_lim = (cnt_q >= lim);
    flt_d  = raw && at_lim;
    if (!raw)        cnt_d = '0;
    else if (at_lim) cnt_d = cnt_q;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flt_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      flt_q <= flt_d;
    end
  end

  assign flt = flt_q;

  // R7 / R8: a low sample clears both the count and the recognized fault
  assert_low_sample_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !raw |=> (cnt_q == '0) && !flt_q);
  assert_fault_needs_raw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_q) |-> $past(raw));
endmodule

// File: rtl/fo_fuse_drive.sv
module fo_fuse_drive
  import fused_out_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ch_ctrl_t ctrl,
  input  logic     cmp_req,
  input  logic     pwm_req,
  input  logic     flt,
  output logic     drive,
  output logic     sts
);
  logic lat_q, lat_d;
  logic drv_q, drv_d;
  logic set_lat, clr_lat;

  always_comb begin
    set_lat = flt && ctrl.fuse_en;
    clr_lat = !ctrl.fuse_en && ctrl.enable;
    if (set_lat)      lat_d = 1'b1;
    else if (clr_lat) lat_d = 1'b0;
    else              lat_d = lat_q;
    drv_d = ctrl.enable && !lat_q && (ctrl.force_on || cmp_req || pwm_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= 1'b0;
      drv_q <= 1'b0;
    end else begin
      lat_q <= lat_d;
      drv_q <= drv_d;
    end
  end

  assign drive = drv_q;
  assign sts   = lat_q | flt;

  assert_disabled_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.enable |=> !drive);
  assert_forced_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.enable && ctrl.force_on && !sts |=> drive);
  assert_latched_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q |=> !drive);
  assert_latch_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q && !(!ctrl.fuse_en && ctrl.enable) |=> sts);
  assert_recovery_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q && !ctrl.fuse_en && ctrl.enable |=> !lat_q);
endmodule

// File: rtl/fused_out_ctl.sv
module fused_out_ctl
  import fused_out_pkg::*;
#(
  parameter int unsigned NUM_CH     = 2,
  parameter int unsigned FAST_TICKS = 1000000,
  parameter int unsigned SLOW_TICKS = 12500000
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_CH*CTRL_BITS_PER_CH-1:0] ctrl_i,
  input  logic [NUM_CH-1:0]                  cmp_req_i,
  input  logic [NUM_CH-1:0]                  pwm_req_i,
  input  logic [NUM_CH-1:0]                  fault_raw_i,
  output logic [NUM_CH-1:0]                  drive_o,
  output logic [NUM_CH-1:0]                  fault_sts_o
);
  logic rst_n_s;

  fo_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    ch_ctrl_t c;
    logic     flt;

    // R4: nibble n of the control word belongs to channel n
    assign c = get_ctrl(ctrl_i[ch*CTRL_BITS_PER_CH +: CTRL_BITS_PER_CH]);

    fo_fault_filter #(
      .FAST_TICKS (FAST_TICKS),
      .SLOW_TICKS (SLOW_TICKS)
    ) u_flt (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .long_sel (c.long_flt),
      .raw      (fault_raw_i[ch]),
      .flt      (flt)
    );

    fo_fuse_drive u_drv (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .ctrl    (c),
      .cmp_req (cmp_req_i[ch]),
      .pwm_req (pwm_req_i[ch]),
      .flt     (flt),
      .drive   (drive_o[ch]),
      .sts     (fault_sts_o[ch])
    );
  end

  assert_reset_quiet_R12: assert property (@(posedge clk)
    !rst_n_s |-> (drive_o == '0) && (fault_sts_o == '0));
endmodule

// File: tb/sim_fused_out_ctl.sv
module sim_fused_out_ctl;
  localparam int unsigned FAST = 6;
  localparam int unsigned SLOW = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctrl = '0;
  logic [1:0] cmp = '0, pwm = '0, raw = '0;
  logic [1:0] drive, sts;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  fused_out_ctl #(.NUM_CH(2), .FAST_TICKS(FAST), .SLOW_TICKS(SLOW)) u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .cmp_req_i(cmp), .pwm_req_i(pwm),
    .fault_raw_i(raw), .drive_o(drive), .fault_sts_o(sts));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_drv(input logic [3:0] nib, input logic c, input logic p);
    return nib[1] && (nib[0] || c || p);
  endfunction

  initial begin
    step(3);
    chk("R12 drive", drive[0] | drive[1], 1'b0);
    chk("R12 status", sts[0] | sts[1], 1'b0);
    rst_n = 1'b1;
    step(3);
    chk("R12 drive after release", drive[0] | drive[1], 1'b0);

    // R1 R2 R3 R4: sweep every control nibble and request pair on both channels
    for (int nib = 0; nib < 16; nib++) begin
      for (int rq = 0; rq < 4; rq++) begin
        ctrl = {~nib[3:0], nib[3:0]};
        cmp  = {~rq[0], rq[0]};
        pwm  = {~rq[1], rq[1]};
        step(1);
        chk("R1/R2/R3/R4 ch0", drive[0], exp_drv(nib[3:0], rq[0], rq[1]));
        chk("R1/R2/R3/R4 ch1", drive[1], exp_drv(~nib[3:0], ~rq[0], ~rq[1]));
      end
    end
    cmp = '0; pwm = '0;

    // R5 fast filter, R8 non-fuse behaviour
    ctrl = 8'h03;
    step(1);
    raw[0] = 1'b1;
    step(FAST - 1);
    chk("R5 before threshold", sts[0], 1'b0);
    step(1);
    chk("R5 at threshold", sts[0], 1'b1);
    chk("R8 drive kept", drive[0], 1'b1);
    raw[0] = 1'b0;
    step(1);
    chk("R8 status drops", sts[0], 1'b0);

    // R7 glitch restarts the count
    raw[0] = 1'b1;
    step(FAST - 1);
    raw[0] = 1'b0;
    step(1);
    raw[0] = 1'b1;
    step(FAST - 1);
    chk("R7 restarted count", sts[0], 1'b0);
    step(1);
    chk("R7 full count", sts[0], 1'b1);
    raw[0] = 1'b0;
    step(1);

    // R6 slow filter
    ctrl = 8'h0B;
    step(1);
    raw[0] = 1'b1;
    step(SLOW - 1);
    chk("R6 before threshold", sts[0], 1'b0);
    step(1);
    chk("R6 at threshold", sts[0], 1'b1);
    raw[0] = 1'b0;
    step(1);

    // R9 fuse latch, R11 other channel untouched
    ctrl = 8'h37;
    step(1);
    raw[0] = 1'b1;
    step(FAST);
    chk("R9 status", sts[0], 1'b1);
    step(2);
    chk("R9 drive off", drive[0], 1'b0);
    chk("R11 ch1 drive", drive[1], 1'b1);
    chk("R11 ch1 status", sts[1], 1'b0);
    raw[0] = 1'b0;
    step(3);
    chk("R9 latch holds status", sts[0], 1'b1);
    chk("R9 latch holds drive", drive[0], 1'b0);

    // R10 recovery rules
    ctrl = 8'h31;
    step(2);
    chk("R10 enable 0 keeps latch", sts[0], 1'b1);
    ctrl = 8'h33;
    step(2);
    chk("R10 recovered status", sts[0], 1'b0);
    chk("R10 recovered drive", drive[0], 1'b1);

    // R4 R11 channel 1 fuse through its own nibble
    ctrl = 8'h73;
    step(1);
    raw[1] = 1'b1;
    step(FAST + 2);
    chk("R4 ch1 status", sts[1], 1'b1);
    chk("R4 ch1 drive off", drive[1], 1'b0);
    chk("R11 ch0 status", sts[0], 1'b0);
    chk("R11 ch0 drive", drive[0], 1'b1);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule